// File: doc/BRIEF.md
# Quadratic forward-difference address sequencer

This block produces one axis of source-image coordinates for a geometric image warp. It walks the output image pixel by pixel, with U counting along a line and V counting lines. The source position follows a quadratic surface in (U, V), and the block evaluates it by second-order forward differencing. Each step is made of additions only. The running position is a 28-bit signed fixed-point value: a sign bit, 11 integer bits and 16 fraction bits. The block outputs the 12 integer bits as the source address. The top fraction bits and a per-pixel walk counter form an 8-bit coefficient address for a downstream interpolation filter. A second instance of the block drives the other axis.

Software loads sixteen 16-bit configuration locations through a 4-bit write address. A one-cycle start pulse copies the configuration into the running state and begins the sweep. The block then presents one source address per filter tap per output pixel, and pulses a completion flag after the last one. The block flags positions that leave the programmed source window, and it can optionally clamp them to that window. A test mode puts the low accumulator bits on the address port for debug.

Top module: `qfd_addr_seq`

## Requirements
- R1: After reset, `valid`, `done` and `out_of_win` are low, and `src_addr` and `coef_addr` are zero.
- R2: Register locations are:
  - 0: window minimum (signed 12-bit, data bits 11:0).
  - 1: window maximum (signed 12-bit).
  - 2 and 3: start position, low half then high half.
  - 4: control. Bit 0 is test mode, bit 1 is clamp, bits 3:2 are the tap exponent.
  - 5 and 6: per-pixel slope, low half then high half.
  - 7 and 8: per-line slope, low half then high half.
  - 9: per-pixel curvature.
  - 10: per-line curvature.
  - 11: mixed curvature.
  - 12: last line index.
  - 13: reserved.
  - 14: first U value.
  - 15: last U value.

  For every split value, the low half supplies bits 15:0 and data bits 11:0 of the high half supply bits 27:16. Each curvature is a 16-bit signed value in fraction units, sign-extended to 28 bits.
- R3: A start pulse sampled at a clock edge loads the running state from the registers. The first pixel is on the outputs, with `valid` high, right after that edge. With a tap exponent of 0, a new pixel follows on every clock.
- R4: Within a line, each pixel step adds the pixel slope to the position, and then adds the pixel curvature to the pixel slope.
- R5: At each line step:
  - A line-start position advances by the line slope, and the position is reloaded from it.
  - The line slope advances by the line curvature.
  - A line copy of the pixel slope advances by the mixed curvature, and the pixel slope is reloaded from that copy.
- R6: Each line runs U from the first to the last U value inclusive, or covers one pixel if the last value is below the first. Lines run from 0 to the last line index inclusive. In the cycle after the final pixel, `valid` is low and `done` is high for exactly one cycle.
- R7: In normal mode, `src_addr` equals position bits 27:16, and `coef_addr[7:4]` equals position bits 15:12.
- R8: `out_of_win` is high, while `valid`, exactly when the signed integer position is below the window minimum or above the window maximum. It is low when `valid` is low.
- R9: With the clamp bit set and test mode off, `src_addr` is replaced by the window minimum or maximum whenever the position lies below or above the window.
- R10: With the test-mode bit set, `src_addr` carries position bit 27 in bit 11 and position bits 10:0 below it. The test-mode bit acts from the cycle after its write, even while idle, so the two halves of the position are read in two separate cycles.
- R11: With tap exponent k, each pixel is held for 2^k cycles. During those cycles `coef_addr[3:0]` counts 0 to 2^k-1 and the position is unchanged.
- R12: Writes to any location other than the test-mode bit during a sweep do not affect that sweep. They take effect at the next start.
- R13: A start pulse during a sweep abandons it without a `done` pulse and restarts from the first pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration location |
| cfg_wdata | input | 16 | Configuration write data |
| start | input | 1 | Load running state and begin a sweep |
| valid | output | 1 | A pixel address is presented |
| done | output | 1 | One-cycle pulse after the last pixel |
| src_addr | output | 12 | Integer source address, or debug bits in test mode |
| coef_addr | output | 8 | Fraction nibble and walk counter |
| out_of_win | output | 1 | Current position lies outside the source window |

## Verification
The bench runs the sweep under several stimulus patterns:
- A constant slope whose start value sets the high half, which shows whether the two load halves are joined correctly.
- A pixel curvature combined with line slope, line curvature and mixed curvature over several lines, which separates each of the five difference terms.
- A falling slope that crosses both window edges, run once unclamped and once clamped, which distinguishes flagging from clamping.
- Multi-tap sweeps, sweeps with a write or a restart in mid-run, and sweeps and idle reads in test mode, which show pixel holding, configuration isolation and live routing of the test-mode bit.

// File: rtl/qfd_pkg.sv
package qfd_pkg;
  parameter int ACC_W  = 28;
  parameter int FRAC_W = 16;
  parameter int INT_W  = ACC_W - FRAC_W;
  parameter int BUS_W  = 16;
  parameter int HI_W   = ACC_W - BUS_W;
  parameter int CNT_W  = 12;
  parameter int WALK_W = 4;
  parameter int KER_W  = 2;
  parameter int ADDR_W = 4;
  parameter int NREG   = 1 << ADDR_W;
  parameter int TEST_LO_W = INT_W - 1;

  localparam logic [ADDR_W-1:0] LOC_WMIN  = 4'd0;
  localparam logic [ADDR_W-1:0] LOC_WMAX  = 4'd1;
  localparam logic [ADDR_W-1:0] LOC_ST_LO = 4'd2;
  localparam logic [ADDR_W-1:0] LOC_ST_HI = 4'd3;
  localparam logic [ADDR_W-1:0] LOC_CTRL  = 4'd4;
  localparam logic [ADDR_W-1:0] LOC_PU_LO = 4'd5;
  localparam logic [ADDR_W-1:0] LOC_PU_HI = 4'd6;
  localparam logic [ADDR_W-1:0] LOC_PV_LO = 4'd7;
  localparam logic [ADDR_W-1:0] LOC_PV_HI = 4'd8;
  localparam logic [ADDR_W-1:0] LOC_CUU   = 4'd9;
  localparam logic [ADDR_W-1:0] LOC_CVV   = 4'd10;
  localparam logic [ADDR_W-1:0] LOC_CUV   = 4'd11;
  localparam logic [ADDR_W-1:0] LOC_LLAST = 4'd12;
  localparam logic [ADDR_W-1:0] LOC_UFRST = 4'd14;
  localparam logic [ADDR_W-1:0] LOC_ULAST = 4'd15;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic signed [INT_W-1:0] pix_t;

  typedef struct packed {
    pix_t               win_lo;
    pix_t               win_hi;
    logic               clamp;
    logic [KER_W-1:0]   tap_exp;
    logic [CNT_W-1:0]   u_first;
    logic [CNT_W-1:0]   u_last;
    logic [CNT_W-1:0]   line_last;
    acc_t               start_pos;
    acc_t               slope_u;
    acc_t               slope_v;
    acc_t               curv_uu;
    acc_t               curv_vv;
    acc_t               curv_uv;
  } seq_cfg_t;
endpackage

// File: rtl/qfd_cfg_regs.sv
module qfd_cfg_regs
  import qfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output seq_cfg_t          cfg,
  output logic              test_mode
);
  logic [BUS_W-1:0] loc_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_loc
    logic hit;
    assign hit = we && (addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loc_q[g] <= '0;
      end else if (hit) begin
        loc_q[g] <= wdata;
      end
    end
  end

  function automatic acc_t join_halves(input logic [BUS_W-1:0] lo,
                                       input logic [BUS_W-1:0] hi);
    return {hi[HI_W-1:0], lo};
  endfunction

  function automatic acc_t widen_curv(input logic [BUS_W-1:0] v);
    return {{HI_W{v[BUS_W-1]}}, v};
  endfunction

  always_comb begin
    cfg.win_lo    = loc_q[LOC_WMIN][INT_W-1:0];
    cfg.win_hi    = loc_q[LOC_WMAX][INT_W-1:0];
    cfg.clamp     = loc_q[LOC_CTRL][1];
    cfg.tap_exp   = loc_q[LOC_CTRL][2 +: KER_W];
    cfg.u_first   = loc_q[LOC_UFRST][CNT_W-1:0];
    cfg.u_last    = loc_q[LOC_ULAST][CNT_W-1:0];
    cfg.line_last = loc_q[LOC_LLAST][CNT_W-1:0];
    cfg.start_pos = join_halves(loc_q[LOC_ST_LO], loc_q[LOC_ST_HI]);
    cfg.slope_u   = join_halves(loc_q[LOC_PU_LO], loc_q[LOC_PU_HI]);
    cfg.slope_v   = join_halves(loc_q[LOC_PV_LO], loc_q[LOC_PV_HI]);
    cfg.curv_uu   = widen_curv(loc_q[LOC_CUU]);
    cfg.curv_vv   = widen_curv(loc_q[LOC_CVV]);
    cfg.curv_uv   = widen_curv(loc_q[LOC_CUV]);
  end

  assign test_mode = loc_q[LOC_CTRL][0];
endmodule

// File: rtl/qfd_stepper.sv
module qfd_stepper
  import qfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  seq_cfg_t          cfg_live,
  output seq_cfg_t          cfg_run,
  output acc_t              pos,
  output logic [WALK_W-1:0] walk,
  output logic              running,
  output logic              done
);
  acc_t              pos_q, pos_n;
  acc_t              lpos_q, lpos_n;
  acc_t              du_q, du_n;
  acc_t              dul_q, dul_n;
  acc_t              dv_q, dv_n;
  logic [CNT_W-1:0]  u_q, u_n;
  logic [CNT_W-1:0]  ln_q, ln_n;
  logic [WALK_W-1:0] walk_q, walk_n;
  logic              run_q, run_n;
  logic              done_q, done_n;
  seq_cfg_t          cfg_q;
  logic [WALK_W-1:0] walk_last;
  acc_t              lpos_adv, dul_adv;

  assign walk_last = WALK_W'((5'd1 << cfg_q.tap_exp) - 5'd1);
  assign lpos_adv  = lpos_q + dv_q;
  assign dul_adv   = dul_q + cfg_q.curv_uv;

  always_comb begin
    pos_n  = pos_q;
    lpos_n = lpos_q;
    du_n   = du_q;
    dul_n  = dul_q;
    dv_n   = dv_q;
    u_n    = u_q;
    ln_n   = ln_q;
    walk_n = walk_q;
    run_n  = run_q;
    done_n = 1'b0;
    if (start) begin
      pos_n  = cfg_live.start_pos;
      lpos_n = cfg_live.start_pos;
      du_n   = cfg_live.slope_u;
      dul_n  = cfg_live.slope_u;
      dv_n   = cfg_live.slope_v;
      u_n    = cfg_live.u_first;
      ln_n   = '0;
      walk_n = '0;
      run_n  = 1'b1;
    end else if (run_q) begin
      if (walk_q != walk_last) begin
        walk_n = walk_q + 1'b1;
      end else begin
        walk_n = '0;
        if (u_q < cfg_q.u_last) begin
          pos_n = pos_q + du_q;
          du_n  = du_q + cfg_q.curv_uu;
          u_n   = u_q + 1'b1;
        end else if (ln_q < cfg_q.line_last) begin
          lpos_n = lpos_adv;
          pos_n  = lpos_adv;
          dv_n   = dv_q + cfg_q.curv_vv;
          dul_n  = dul_adv;
          du_n   = dul_adv;
          u_n    = cfg_q.u_first;
          ln_n   = ln_q + 1'b1;
        end else begin
          run_n  = 1'b0;
          done_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      lpos_q <= '0;
      du_q   <= '0;
      dul_q  <= '0;
      dv_q   <= '0;
      u_q    <= '0;
      ln_q   <= '0;
      walk_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pos_q  <= pos_n;
      lpos_q <= lpos_n;
      du_q   <= du_n;
      dul_q  <= dul_n;
      dv_q   <= dv_n;
      u_q    <= u_n;
      ln_q   <= ln_n;
      walk_q <= walk_n;
      run_q  <= run_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (start) begin
      cfg_q <= cfg_live;
    end
  end

  assign cfg_run = cfg_q;
  assign pos     = pos_q;
  assign walk    = walk_q;
  assign running = run_q;
  assign done    = done_q;
endmodule

// File: rtl/qfd_out_fmt.sv
module qfd_out_fmt
  import qfd_pkg::*;
(
  input  acc_t              pos,
  input  logic [WALK_W-1:0] walk,
  input  logic              running,
  input  logic              test_mode,
  input  logic              clamp,
  input  pix_t              win_lo,
  input  pix_t              win_hi,
  output logic [INT_W-1:0]  src_addr,
  output logic [7:0]        coef_addr,
  output logic              out_of_win
);
  pix_t int_part;
  logic below, above;
  pix_t normal;

  assign int_part = pos[ACC_W-1:FRAC_W];
  assign below    = int_part < win_lo;
  assign above    = int_part > win_hi;

  always_comb begin
    normal = int_part;
    if (clamp && below) begin
      normal = win_lo;
    end else if (clamp && above) begin
      normal = win_hi;
    end
    if (test_mode) begin
      src_addr = {pos[ACC_W-1], pos[TEST_LO_W-1:0]};
    end else begin
      src_addr = normal;
    end
  end

  assign coef_addr  = {pos[FRAC_W-1 -: 4], walk};
  assign out_of_win = running && (below || above);
endmodule

// File: rtl/qfd_addr_seq.sv
module qfd_addr_seq
  import qfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [15:0] cfg_wdata,
  input  logic        start,
  output logic        valid,
  output logic        done,
  output logic [11:0] src_addr,
  output logic [7:0]  coef_addr,
  output logic        out_of_win
);
  logic              rst_meta, rst_s;
  seq_cfg_t          cfg_live, cfg_run;
  logic              tm_live;
  acc_t              pos;
  logic [WALK_W-1:0] walk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  qfd_cfg_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_s),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .cfg       (cfg_live),
    .test_mode (tm_live)
  );

  qfd_stepper u_step (
    .clk      (clk),
    .rst_n    (rst_s),
    .start    (start),
    .cfg_live (cfg_live),
    .cfg_run  (cfg_run),
    .pos      (pos),
    .walk     (walk),
    .running  (valid),
    .done     (done)
  );

  qfd_out_fmt u_fmt (
    .pos        (pos),
    .walk       (walk),
    .running    (valid),
    .test_mode  (tm_live),
    .clamp      (cfg_run.clamp),
    .win_lo     (cfg_run.win_lo),
    .win_hi     (cfg_run.win_hi),
    .src_addr   (src_addr),
    .coef_addr  (coef_addr),
    .out_of_win (out_of_win)
  );
endmodule

// File: rtl/qfd_addr_seq_chk.sv
module qfd_addr_seq_chk (
  input logic        clk,
  input logic        rst_s,
  input logic        valid,
  input logic        done,
  input logic        out_of_win,
  input logic [11:0] src_addr,
  input logic [7:0]  coef_addr,
  input logic        tm,
  input logic        clamp,
  input logic [11:0] win_lo,
  input logic [11:0] win_hi,
  input logic [1:0]  tap_exp
);
  logic [4:0] taps;
  assign taps = 5'd1 << tap_exp;

  // R6: completion pulse lasts one cycle
  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  // R6: completion follows an active cycle and ends the sweep
  a_r6_done_after_sweep: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (!valid && $past(valid)));

  // R8: window flag only while presenting pixels
  a_r8_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_s)
    out_of_win |-> valid);

  // R9: clamped output stays in the window
  a_r9_clamp_in_window: assert property (@(posedge clk) disable iff (!rst_s)
    (valid && clamp && !tm && ($signed(win_lo) <= $signed(win_hi)))
      |-> ($signed(src_addr) >= $signed(win_lo) && $signed(src_addr) <= $signed(win_hi)));

  // R11: walk counter bounded by tap count
  a_r11_walk_bound: assert property (@(posedge clk) disable iff (!rst_s)
    valid |-> ({1'b0, coef_addr[3:0]} < taps));

  // R11: fraction nibble held during the taps of a pixel
  a_r11_hold_fraction: assert property (@(posedge clk) disable iff (!rst_s)
    (valid && $past(valid) && coef_addr[3:0] != 4'd0) |-> $stable(coef_addr[7:4]));
endmodule

bind qfd_addr_seq qfd_addr_seq_chk u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .valid      (valid),
  .done       (done),
  .out_of_win (out_of_win),
  .src_addr   (src_addr),
  .coef_addr  (coef_addr),
  .tm         (tm_live),
  .clamp      (cfg_run.clamp),
  .win_lo     (cfg_run.win_lo),
  .win_hi     (cfg_run.win_hi),
  .tap_exp    (cfg_run.tap_exp)
);

// File: tb/qfd_addr_seq_tb.sv
`timescale 1ns/1ps
module qfd_addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        start = 1'b0;
  logic        valid, done, out_of_win;
  logic [11:0] src_addr;
  logic [7:0]  coef_addr;

  int checks = 0;
  int errors = 0;

  longint p_start, p_du, p_dv;
  int     p_duu, p_dvv, p_duv;
  int     p_min, p_max, p_ufirst, p_ulast, p_lines, p_kexp;
  bit     p_tm, p_fov;
  longint last_pos;

  always #4 clk = ~clk;

  qfd_addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .valid(valid), .done(done),
    .src_addr(src_addr), .coef_addr(coef_addr), .out_of_win(out_of_win)
  );

  function automatic longint wrap28(longint v);
    longint m;
    m = v & 64'h0FFF_FFFF;
    if (m[27]) m = m - 64'h1000_0000;
    return m;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_all();
    wr(4'd0, 16'(p_min & 'hFFF));
    wr(4'd1, 16'(p_max & 'hFFF));
    wr(4'd2, 16'(p_start & 'hFFFF));
    wr(4'd3, 16'((p_start >> 16) & 'hFFF));
    wr(4'd4, 16'({p_kexp[1:0], p_fov, p_tm}));
    wr(4'd5, 16'(p_du & 'hFFFF));
    wr(4'd6, 16'((p_du >> 16) & 'hFFF));
    wr(4'd7, 16'(p_dv & 'hFFFF));
    wr(4'd8, 16'((p_dv >> 16) & 'hFFF));
    wr(4'd9, 16'(p_duu & 'hFFFF));
    wr(4'd10, 16'(p_dvv & 'hFFFF));
    wr(4'd11, 16'(p_duv & 'hFFFF));
    wr(4'd12, 16'(p_lines));
    wr(4'd13, 16'h0000);
    wr(4'd14, 16'(p_ufirst));
    wr(4'd15, 16'(p_ulast));
  endtask

  task automatic defaults();
    p_start = 0; p_du = 0; p_dv = 0; p_duu = 0; p_dvv = 0; p_duv = 0;
    p_min = -2048; p_max = 2047; p_ufirst = 0; p_ulast = 0; p_lines = 0;
    p_kexp = 0; p_tm = 0; p_fov = 0;
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic longint exp_addr(longint pos);
    longint ia;
    ia = pos >>> 16;
    if (p_tm) return (((pos >> 27) & 1) << 11) | (pos & 'h7FF);
    if (p_fov && ia < p_min) ia = p_min;
    if (p_fov && ia > p_max) ia = p_max;
    return ia & 'hFFF;
  endfunction

  task automatic check_pixel(string req, longint pos, int w);
    longint ia;
    ia = pos >>> 16;
    check(req, "valid", longint'(valid), 1);
    check(req, "src_addr", longint'(src_addr), exp_addr(pos));
    check(req, "coef_addr", longint'(coef_addr), (((pos >> 12) & 'hF) << 4) | w);
    check(req, "out_of_win", longint'(out_of_win), (ia < p_min || ia > p_max) ? 1 : 0);
  endtask

  // Expects the first pixel on the outputs at the current negedge.
  task automatic expect_sweep(string req, int mid_step, logic [3:0] mid_a, logic [15:0] mid_d);
    longint pos, lp, du, dl, dv;
    int npix, taps, step;
    pos = p_start; lp = p_start; du = p_du; dl = p_du; dv = p_dv;
    npix = (p_ulast >= p_ufirst) ? (p_ulast - p_ufirst + 1) : 1;
    taps = 1 << p_kexp;
    step = 0;
    for (int ln = 0; ln <= p_lines; ln++) begin
      for (int u = 0; u < npix; u++) begin
        for (int w = 0; w < taps; w++) begin
          check_pixel(req, pos, w);
          check(req, "done during sweep", longint'(done), 0);
          if (step == mid_step) begin
            cfg_we = 1'b1; cfg_addr = mid_a; cfg_wdata = mid_d;
          end else begin
            cfg_we = 1'b0;
          end
          step++;
          @(negedge clk);
        end
        if (u < npix - 1) begin
          pos = wrap28(pos + du);
          du  = wrap28(du + p_duu);
        end
      end
      if (ln < p_lines) begin
        lp  = wrap28(lp + dv);
        pos = lp;
        dv  = wrap28(dv + p_dvv);
        dl  = wrap28(dl + p_duv);
        du  = dl;
      end
    end
    cfg_we = 1'b0;
    last_pos = pos;
    check("R6", "done after last", longint'(done), 1);
    check("R6", "valid after last", longint'(valid), 0);
    @(negedge clk);
    check("R6", "done one cycle", longint'(done), 0);
  endtask

  task automatic t_reset();
    check("R1", "valid", longint'(valid), 0);
    check("R1", "done", longint'(done), 0);
    check("R1", "out_of_win", longint'(out_of_win), 0);
    check("R1", "src_addr", longint'(src_addr), 0);
    check("R1", "coef_addr", longint'(coef_addr), 0);
  endtask

  task automatic t_linear();
    defaults();
    p_start = 28'sh0123_4000;
    p_du = 28'sh0001_8000; p_ulast = 5;
    load_all(); kick();
    expect_sweep("R2 R3 R4 R7", -1, 4'd0, 16'd0);
  endtask

  task automatic t_quadratic();
    defaults();
    p_start = 28'sh0040_0000;
    p_du = 28'sh0002_0000; p_duu = 'h0800;
    p_dv = 28'sh0010_0000; p_dvv = -'h4000; p_duv = 'h1000;
    p_ufirst = 3; p_ulast = 7; p_lines = 3;
    load_all(); kick();
    expect_sweep("R4 R5 R6", -1, 4'd0, 16'd0);
  endtask

  task automatic t_window(bit fov);
    defaults();
    p_start = 28'sh0006_0000;
    p_du = -28'sh0001_0000;
    p_dv = 28'sh0008_0000;
    p_min = 2; p_max = 8; p_ulast = 6; p_lines = 1; p_fov = fov;
    load_all(); kick();
    expect_sweep(fov ? "R9" : "R8", -1, 4'd0, 16'd0);
  endtask

  task automatic t_testmode();
    defaults();
    p_start = -28'sh0003_0ABC;
    p_du = 28'sh0000_0123; p_ulast = 4; p_tm = 1;
    load_all(); kick();
    expect_sweep("R10", -1, 4'd0, 16'd0);
    // idle: flip the mode bit and read both halves of the held position
    wr(4'd4, 16'h0000);
    p_tm = 0;
    check("R10", "idle normal half", longint'(src_addr), exp_addr(last_pos));
    wr(4'd4, 16'h0001);
    p_tm = 1;
    check("R10", "idle debug half", longint'(src_addr), exp_addr(last_pos));
    wr(4'd4, 16'h0000);
    p_tm = 0;
  endtask

  task automatic t_taps();
    defaults();
    p_start = 28'sh0010_0000;
    p_du = 28'sh0000_4000; p_ulast = 3; p_lines = 1;
    p_dv = 28'sh0001_0000; p_kexp = 2;
    load_all(); kick();
    expect_sweep("R11", -1, 4'd0, 16'd0);
  endtask

  task automatic t_isolation();
    defaults();
    p_start = 28'sh0020_0000;
    p_du = 28'sh0001_0000; p_ulast = 6;
    load_all(); kick();
    // change the pixel slope low half mid-sweep; this sweep ignores it
    expect_sweep("R12", 2, 4'd5, 16'h8000);
    p_du = 28'sh0001_8000;
    kick();
    expect_sweep("R12", -1, 4'd0, 16'd0);
  endtask

  task automatic t_restart();
    defaults();
    p_start = 28'sh0030_0000;
    p_du = 28'sh0002_0000; p_ulast = 5;
    load_all(); kick();
    for (int i = 0; i < 3; i++) begin
      check("R13", "running before restart", longint'(valid), 1);
      @(negedge clk);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R13", "no done on restart", longint'(done), 0);
    expect_sweep("R13", -1, 4'd0, 16'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_linear();
    t_quadratic();
    t_window(1'b0);
    t_window(1'b1);
    t_testmode();
    t_taps();
    t_isolation();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule